// File: doc/BRIEF.md
# Flash command interface controller

This block sits between a parallel asynchronous-style host bus and the internals of a flash device. Every bus pin is sampled in the system clock domain. Each write strobe carries an 8-bit command code on the low byte of the data bus. The block decodes that code into an operating mode, or into the first half of a two-write sequence. Program, erase and protection jobs start only when the whole sequence has arrived. The job itself is modelled by a busy timer whose length depends on the kind of job.

The block keeps one status register for each memory partition. The partition is selected by the top bits of the address. Each read strobe returns one of four things, chosen by the current read mode: array data from outside the block, the status byte of the addressed partition, an identifier word, or a query word. While a job is running, only the status and suspend commands are acted on. A job can be paused and later resumed, and it keeps its remaining cycle count while paused.

Top module: `flash_cmd_if`

## Requirements
- R1: A write event is counted once for each assertion of the write strobe: chip_sel_n low, wr_en_n low, rd_en_n high and bus_rst_n high. A strobe held over several clocks counts once. A strobe with rd_en_n low is ignored.
- R2: After rst_n is low, or after bus_rst_n is low for a clock, the block is in read-array mode. No job runs, dq_oe is low, and every partition's status byte is 0x80.
- R3: In read-array mode, a read strobe (chip_sel_n and rd_en_n low, wr_en_n and bus_rst_n high) sampled on one clock gives dq_oe=1 and dq_out equal to that clock's array_rdata after the edge.
- R4: After code 0x70, each read returns {8'h00, status byte} of the partition named by addr[ADDR_W-1]. The status byte bits are: bit 7 = ready (0 only while that partition's job runs), bit 6 = erase paused, bits 5 and 4 = sequence error, bit 2 = program paused, and all other bits 0.
- R5: After 0x90, a read at offset 0 returns MFR_ID, offset 1 returns DEV_ID, and any other offset returns 0. After 0x98, offsets 0, 1 and 2 return 0x51, 0x52 and 0x59, and any other offset returns 0. The offset is addr[ADDR_W-2:0].
- R6: 0x40, 0x10, 0x30 or 0xC0, followed by any write, starts a program job in the partition of the second write. wsm_busy stays high for exactly PROG_CYC clock samples, and the mode becomes status.
- R7: 0x20 followed by 0xD0 starts an erase job of ERASE_CYC samples.
- R8: After 0x20 or 0x60, a second write other than 0xD0 sets bits 5 and 4 of the second write's partition, starts no job, and selects status mode. An undefined code written while idle does the same.
- R9: 0x50 clears the error bits of the addressed partition only. Otherwise the error bits survive every mode change.
- R10: While a job runs, only 0x70 and 0xB0 have an effect. All other codes are dropped and no sequence is opened. Reads return status.
- R11: 0xB0 pauses the job: wsm_busy drops, bit 7 reads 1, and bit 6 (erase) or bit 2 (program) is set. In this state 0x70, 0xFF, 0x90 and 0x98 change the mode, and 0xD0 resumes the job. The count is frozen while paused, so busy samples total the job length plus one.
- R12: 0x60 followed by 0xD0 starts a protection job of PROG_CYC samples.
- R13: dq_oe is high only on the clock after a sampled read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| chip_sel_n | input | 1 | Active-low chip select |
| wr_en_n | input | 1 | Active-low write strobe |
| rd_en_n | input | 1 | Active-low output enable |
| bus_rst_n | input | 1 | Active-low bus reset, sampled |
| addr | input | ADDR_W | Word address; the top bits pick the partition |
| dq_in | input | 16 | Write data; bits 7:0 carry the command |
| array_rdata | input | 16 | Array word for the current address |
| dq_out | output | 16 | Registered read data |
| dq_oe | output | 1 | Read data valid / drive enable |
| wsm_busy | output | 1 | Job running and not paused |

## Verification
Random mode-select writes, each followed by reads at random offsets, exercise the four read sources. These distinguish array, status, identifier and query routing, and in-range offsets from out-of-range ones. Directed sequences cover every program opener, erase, protection and bad confirms in both partitions. These show that a job starts only on a complete sequence and that errors land in the right partition. Busy-sample counts across pause and resume separate a frozen counter from one that keeps running or restarts. Commands written during a job show which codes are filtered.

// File: rtl/fci_pkg.sv
package fci_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_STATUS = 2'd1,
        MODE_IDENT  = 2'd2,
        MODE_QUERY  = 2'd3
    } rd_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PROG  = 2'd1,
        SEQ_ERASE = 2'd2,
        SEQ_PROT  = 2'd3
    } seq_e;

    localparam logic [7:0] OP_PROG     = 8'h40;
    localparam logic [7:0] OP_PROG_ALT = 8'h10;
    localparam logic [7:0] OP_ERASE    = 8'h20;
    localparam logic [7:0] OP_FAST     = 8'h30;
    localparam logic [7:0] OP_CLRSR    = 8'h50;
    localparam logic [7:0] OP_PROT     = 8'h60;
    localparam logic [7:0] OP_RDSR     = 8'h70;
    localparam logic [7:0] OP_RDID     = 8'h90;
    localparam logic [7:0] OP_QUERY    = 8'h98;
    localparam logic [7:0] OP_SUSPEND  = 8'hB0;
    localparam logic [7:0] OP_PLOCK    = 8'hC0;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_RDARR    = 8'hFF;

    localparam int SR_READY  = 7;
    localparam int SR_ESUSP  = 6;
    localparam int SR_ERR_HI = 5;
    localparam int SR_ERR_LO = 4;
    localparam int SR_PSUSP  = 2;

endpackage

// File: rtl/fci_bus_sampler.sv
module fci_bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic chip_sel_n,
    input  logic wr_en_n,
    input  logic rd_en_n,
    input  logic bus_rst_n,
    output logic wr_evt,
    output logic rd_cyc
);
    typedef struct packed {
        logic wr_seen;
    } smp_t;

    smp_t smp_d, smp_q;
    logic wr_cyc;

    always_comb begin
        wr_cyc        = !chip_sel_n && !wr_en_n && rd_en_n && bus_rst_n;
        rd_cyc        = !chip_sel_n && !rd_en_n && wr_en_n && bus_rst_n;
        smp_d.wr_seen = wr_cyc;
        wr_evt        = wr_cyc && !smp_q.wr_seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end
endmodule

// File: rtl/fci_wsm_timer.sv
module fci_wsm_timer #(
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic start,
    input  logic start_erase,
    input  logic suspend,
    input  logic resume,
    output logic running,
    output logic paused,
    output logic op_erase
);
    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic             active;
        logic             hold;
        logic             erase;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (abort) begin
            tmr_d = '0;
        end else if (start) begin
            tmr_d.active = 1'b1;
            tmr_d.hold   = 1'b0;
            tmr_d.erase  = start_erase;
            tmr_d.cnt    = start_erase ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
        end else if (tmr_q.active) begin
            if (tmr_q.hold) begin
                if (resume) tmr_d.hold = 1'b0;
            end else if (suspend) begin
                tmr_d.hold = 1'b1;
            end else if (tmr_q.cnt <= CNT_W'(1)) begin
                tmr_d.active = 1'b0;
                tmr_d.cnt    = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign running  = tmr_q.active && !tmr_q.hold;
    assign paused   = tmr_q.active && tmr_q.hold;
    assign op_erase = tmr_q.erase;
endmodule

// File: rtl/fci_read_mux.sv
module fci_read_mux
    import fci_pkg::*;
#(
    parameter int          OFS_W  = 15,
    parameter logic [15:0] MFR_ID = 16'h00A5,
    parameter logic [15:0] DEV_ID = 16'h5C3E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_cyc,
    input  rd_mode_e         mode,
    input  logic [OFS_W-1:0] offset,
    input  logic [15:0]      array_rdata,
    input  logic [7:0]       status_byte,
    output logic [15:0]      dq_out,
    output logic             dq_oe
);
    typedef struct packed {
        logic        oe;
        logic [15:0] data;
    } rdo_t;

    rdo_t rdo_d, rdo_q;

    always_comb begin
        rdo_d.oe   = rd_cyc;
        rdo_d.data = '0;
        if (rd_cyc) begin
            case (mode)
                MODE_ARRAY:  rdo_d.data = array_rdata;
                MODE_STATUS: rdo_d.data = {8'h00, status_byte};
                MODE_IDENT: begin
                    if (offset == OFS_W'(0))      rdo_d.data = MFR_ID;
                    else if (offset == OFS_W'(1)) rdo_d.data = DEV_ID;
                end
                MODE_QUERY: begin
                    if (offset == OFS_W'(0))      rdo_d.data = 16'h0051;
                    else if (offset == OFS_W'(1)) rdo_d.data = 16'h0052;
                    else if (offset == OFS_W'(2)) rdo_d.data = 16'h0059;
                end
                default: rdo_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdo_q <= '0;
        else        rdo_q <= rdo_d;
    end

    assign dq_out = rdo_q.data;
    assign dq_oe  = rdo_q.oe;
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import fci_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          NUM_PART  = 2,
    parameter int          PROG_CYC  = 8,
    parameter int          ERASE_CYC = 40,
    parameter logic [15:0] MFR_ID    = 16'h00A5,
    parameter logic [15:0] DEV_ID    = 16'h5C3E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              wr_en_n,
    input  logic              rd_en_n,
    input  logic              bus_rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    input  logic [15:0]       array_rdata,
    output logic [15:0]       dq_out,
    output logic              dq_oe,
    output logic              wsm_busy
);
    // NUM_PART must be a power of two, at least 2
    localparam int PART_BITS = $clog2(NUM_PART);
    localparam int OFS_W     = ADDR_W - PART_BITS;

    typedef struct packed {
        rd_mode_e               mode;
        seq_e                   seq;
        logic [PART_BITS-1:0]   job_part;
        logic [NUM_PART-1:0]    err;
    } dec_t;

    dec_t dec_d, dec_q;

    logic                 wr_evt, rd_cyc;
    logic                 t_start, t_erase, t_susp, t_resume;
    logic                 run, paused, op_erase;
    logic [7:0]           cmd;
    logic [PART_BITS-1:0] part_sel;
    logic [7:0]           status_byte;
    logic                 job_here;
    logic [7:0]           unused_hi;
    rd_mode_e             cur_mode;

    assign cmd       = dq_in[7:0];
    assign unused_hi = dq_in[15:8];
    assign part_sel  = addr[ADDR_W-1 -: PART_BITS];
    assign cur_mode  = dec_q.mode;

    fci_bus_sampler u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_sel_n (chip_sel_n),
        .wr_en_n    (wr_en_n),
        .rd_en_n    (rd_en_n),
        .bus_rst_n  (bus_rst_n),
        .wr_evt     (wr_evt),
        .rd_cyc     (rd_cyc)
    );

    // command decoder: next state
    always_comb begin
        dec_d    = dec_q;
        t_start  = 1'b0;
        t_erase  = 1'b0;
        t_susp   = 1'b0;
        t_resume = 1'b0;
        if (wr_evt) begin
            if (dec_q.seq != SEQ_IDLE) begin
                dec_d.seq  = SEQ_IDLE;
                dec_d.mode = MODE_STATUS;
                if (dec_q.seq == SEQ_PROG || cmd == OP_CONFIRM) begin
                    t_start        = 1'b1;
                    t_erase        = (dec_q.seq == SEQ_ERASE);
                    dec_d.job_part = part_sel;
                end else begin
                    dec_d.err[part_sel] = 1'b1;
                end
            end else if (run) begin
                if (cmd == OP_RDSR) begin
                    dec_d.mode = MODE_STATUS;
                end else if (cmd == OP_SUSPEND) begin
                    t_susp     = 1'b1;
                    dec_d.mode = MODE_STATUS;
                end
            end else if (paused) begin
                case (cmd)
                    OP_RDSR:  dec_d.mode = MODE_STATUS;
                    OP_RDARR: dec_d.mode = MODE_ARRAY;
                    OP_RDID:  dec_d.mode = MODE_IDENT;
                    OP_QUERY: dec_d.mode = MODE_QUERY;
                    OP_CONFIRM: begin
                        t_resume   = 1'b1;
                        dec_d.mode = MODE_STATUS;
                    end
                    default: dec_d.mode = dec_q.mode;
                endcase
            end else begin
                case (cmd)
                    OP_PROG, OP_PROG_ALT, OP_FAST, OP_PLOCK: begin
                        dec_d.seq  = SEQ_PROG;
                        dec_d.mode = MODE_STATUS;
                    end
                    OP_ERASE: begin
                        dec_d.seq  = SEQ_ERASE;
                        dec_d.mode = MODE_STATUS;
                    end
                    OP_PROT: begin
                        dec_d.seq  = SEQ_PROT;
                        dec_d.mode = MODE_STATUS;
                    end
                    OP_CLRSR:             dec_d.err[part_sel] = 1'b0;
                    OP_RDSR:              dec_d.mode = MODE_STATUS;
                    OP_RDID:              dec_d.mode = MODE_IDENT;
                    OP_QUERY:             dec_d.mode = MODE_QUERY;
                    OP_RDARR:             dec_d.mode = MODE_ARRAY;
                    OP_SUSPEND, OP_CONFIRM: dec_d.mode = dec_q.mode;
                    default: begin
                        dec_d.err[part_sel] = 1'b1;
                        dec_d.mode          = MODE_STATUS;
                    end
                endcase
            end
        end
        if (!bus_rst_n) begin
            dec_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    fci_wsm_timer #(
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort       (!bus_rst_n),
        .start       (t_start),
        .start_erase (t_erase),
        .suspend     (t_susp),
        .resume      (t_resume),
        .running     (run),
        .paused      (paused),
        .op_erase    (op_erase)
    );

    // status byte of the addressed partition
    always_comb begin
        job_here               = (dec_q.job_part == part_sel);
        status_byte            = '0;
        status_byte[SR_READY]  = !(run && job_here);
        status_byte[SR_ESUSP]  = paused && op_erase && job_here;
        status_byte[SR_ERR_HI] = dec_q.err[part_sel];
        status_byte[SR_ERR_LO] = dec_q.err[part_sel];
        status_byte[SR_PSUSP]  = paused && !op_erase && job_here;
    end

    fci_read_mux #(
        .OFS_W  (OFS_W),
        .MFR_ID (MFR_ID),
        .DEV_ID (DEV_ID)
    ) u_rdmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_cyc      (rd_cyc),
        .mode        (cur_mode),
        .offset      (addr[OFS_W-1:0]),
        .array_rdata (array_rdata),
        .status_byte (status_byte),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe)
    );

    assign wsm_busy = run;
endmodule

// File: rtl/fci_checker.sv
module fci_checker
    import fci_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        chip_sel_n,
    input logic        wr_en_n,
    input logic        rd_en_n,
    input logic        bus_rst_n,
    input logic [15:0] array_rdata,
    input logic [15:0] dq_out,
    input logic        dq_oe,
    input logic        wsm_busy,
    input rd_mode_e    cur_mode
);
    logic rd_now, wr_now;
    assign rd_now = !chip_sel_n && !rd_en_n && wr_en_n && bus_rst_n;
    assign wr_now = !chip_sel_n && !wr_en_n && rd_en_n && bus_rst_n;

    // R13
    oe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(rd_now));

    // R6
    busy_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wsm_busy) |-> $past(wr_now));

    // R2
    bus_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n |=> (!wsm_busy && !dq_oe && cur_mode == MODE_ARRAY));

    // R3
    array_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_ARRAY && rd_now) |=> (dq_oe && dq_out == $past(array_rdata)));

    // R4
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_STATUS && rd_now) |=> (dq_out[15:8] == 8'h00));

    // R10
    busy_status_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wsm_busy |-> (cur_mode == MODE_STATUS));
endmodule

bind flash_cmd_if fci_checker u_fci_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_sel_n  (chip_sel_n),
    .wr_en_n     (wr_en_n),
    .rd_en_n     (rd_en_n),
    .bus_rst_n   (bus_rst_n),
    .array_rdata (array_rdata),
    .dq_out      (dq_out),
    .dq_oe       (dq_oe),
    .wsm_busy    (wsm_busy),
    .cur_mode    (cur_mode)
);

// File: tb/flash_cmd_if_bench.sv
module flash_cmd_if_bench;
    localparam int          AW  = 16;
    localparam int          PC  = 8;
    localparam int          EC  = 40;
    localparam logic [15:0] MFR = 16'h00A5;
    localparam logic [15:0] DEV = 16'h5C3E;
    localparam logic [15:0] P1  = 16'h8000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_sel_n = 1'b1, wr_en_n = 1'b1, rd_en_n = 1'b1, bus_rst_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   array_rdata;
    logic [15:0]   dq_out;
    logic          dq_oe, wsm_busy;

    int vectors = 0;
    int misses = 0;
    int busy_samples = 0;
    int unsigned seed_dummy;

    always #5 clk = ~clk;

    function automatic logic [15:0] arr_fn(input logic [15:0] a);
        return {a[7:0] ^ 8'h3C, a[15:8] + 8'h11};
    endfunction

    function automatic logic [15:0] exp_ident(input logic [14:0] off);
        if (off == 15'd0) return MFR;
        if (off == 15'd1) return DEV;
        return 16'h0000;
    endfunction

    function automatic logic [15:0] exp_query(input logic [14:0] off);
        if (off == 15'd0) return 16'h0051;
        if (off == 15'd1) return 16'h0052;
        if (off == 15'd2) return 16'h0059;
        return 16'h0000;
    endfunction

    function automatic logic [15:0] exp_sr(input logic rdy, input logic esus,
                                           input logic err, input logic psus);
        return {8'h00, rdy, esus, err, err, 1'b0, psus, 2'b00};
    endfunction

    assign array_rdata = arr_fn(addr);

    flash_cmd_if #(
        .ADDR_W (AW), .NUM_PART (2), .PROG_CYC (PC), .ERASE_CYC (EC),
        .MFR_ID (MFR), .DEV_ID (DEV)
    ) u_flash_cmd_if (
        .clk (clk), .rst_n (rst_n), .chip_sel_n (chip_sel_n), .wr_en_n (wr_en_n),
        .rd_en_n (rd_en_n), .bus_rst_n (bus_rst_n), .addr (addr), .dq_in (dq_in),
        .array_rdata (array_rdata), .dq_out (dq_out), .dq_oe (dq_oe), .wsm_busy (wsm_busy)
    );

    always @(negedge clk) if (wsm_busy) busy_samples++;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; dq_in = d; chip_sel_n = 1'b0; wr_en_n = 1'b0; rd_en_n = 1'b1;
        @(negedge clk);
        wr_en_n = 1'b1; chip_sel_n = 1'b1;
    endtask

    task automatic bus_write_held(input logic [15:0] a, input logic [15:0] d, input int n);
        @(negedge clk);
        addr = a; dq_in = d; chip_sel_n = 1'b0; wr_en_n = 1'b0; rd_en_n = 1'b1;
        repeat (n) @(negedge clk);
        wr_en_n = 1'b1; chip_sel_n = 1'b1;
    endtask

    task automatic bus_write_oe_low(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; dq_in = d; chip_sel_n = 1'b0; wr_en_n = 1'b0; rd_en_n = 1'b0;
        @(negedge clk);
        wr_en_n = 1'b1; chip_sel_n = 1'b1; rd_en_n = 1'b1;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] d, output logic oe);
        @(negedge clk);
        addr = a; chip_sel_n = 1'b0; rd_en_n = 1'b0; wr_en_n = 1'b1;
        @(negedge clk);
        d = dq_out; oe = dq_oe;
        chip_sel_n = 1'b1; rd_en_n = 1'b1;
    endtask

    task automatic read_check(input string req, input logic [15:0] a, input logic [15:0] exp);
        logic [15:0] d;
        logic oe;
        bus_read(a, d, oe);
        check(req, {15'd0, oe}, 16'h0001);
        check(req, d, exp);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (wsm_busy && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        logic [15:0] a;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 oe at reset", {15'd0, dq_oe}, 16'h0000);
        check("R2 busy at reset", {15'd0, wsm_busy}, 16'h0000);
        check("R13 oe idle", {15'd0, dq_oe}, 16'h0000);

        // R3: read-array right after reset
        for (int i = 0; i < 24; i++) begin
            a = 16'($urandom);
            read_check("R3 array", a, arr_fn(a));
        end

        // R2, R4: clean status in both partitions
        bus_write(16'h0000, 16'h0070);
        read_check("R2 status p0", 16'h0011, exp_sr(1, 0, 0, 0));
        read_check("R4 status p1", P1 | 16'h0203, exp_sr(1, 0, 0, 0));

        // R1: write with output enable low is ignored
        bus_write(16'h0000, 16'h00FF);
        bus_write_oe_low(16'h0000, 16'h0098);
        read_check("R1 oe-low write ignored", 16'h0003, arr_fn(16'h0003));
        // R1: held strobe counts once
        busy_samples = 0;
        bus_write_held(16'h0000, 16'h0020, 4);
        bus_write(16'h0000, 16'h00D0);
        check("R1 held strobe once", {15'd0, wsm_busy}, 16'h0001);
        wait_idle();

        // R5: identifier and query space
        bus_write(16'h0000, 16'h0090);
        for (int o = 0; o < 4; o++) begin
            read_check("R5 ident p0", 16'(o), exp_ident(15'(o)));
            read_check("R5 ident p1", P1 | 16'(o), exp_ident(15'(o)));
        end
        bus_write(P1, 16'h0098);
        for (int o = 0; o < 5; o++) read_check("R5 query", 16'(o), exp_query(15'(o)));

        // R6: every program opener
        for (int k = 0; k < 4; k++) begin
            logic [15:0] code;
            code = (k == 0) ? 16'h0040 : (k == 1) ? 16'h0010 : (k == 2) ? 16'h0030 : 16'h00C0;
            busy_samples = 0;
            bus_write(P1, code);
            bus_write(P1 | 16'h0123, 16'hBEEF);
            check("R6 busy after program", {15'd0, wsm_busy}, 16'h0001);
            read_check("R6 status busy p1", P1, exp_sr(0, 0, 0, 0));
            read_check("R6 status other p0", 16'h0000, exp_sr(1, 0, 0, 0));
            wait_idle();
            check("R6 program length", 16'(busy_samples), 16'(PC));
            read_check("R6 status done p1", P1, exp_sr(1, 0, 0, 0));
        end

        // R7: erase
        busy_samples = 0;
        bus_write(16'h0040, 16'h0020);
        bus_write(16'h0040, 16'h00D0);
        read_check("R7 status erasing", 16'h0000, exp_sr(0, 0, 0, 0));
        wait_idle();
        check("R7 erase length", 16'(busy_samples), 16'(EC));

        // R10: commands filtered while busy
        busy_samples = 0;
        bus_write(P1, 16'h0020);
        bus_write(P1, 16'h00D0);
        bus_write(16'h0000, 16'h00FF);
        bus_write(16'h0000, 16'h0090);
        bus_write(16'h0000, 16'h0040);
        read_check("R10 reads status while busy", P1, exp_sr(0, 0, 0, 0));
        check("R10 still busy", {15'd0, wsm_busy}, 16'h0001);
        wait_idle();
        check("R10 length undisturbed", 16'(busy_samples), 16'(EC));
        bus_write(16'h0000, 16'h00FF);
        check("R10 no latched setup", {15'd0, wsm_busy}, 16'h0000);
        read_check("R10 array after job", 16'h1234, arr_fn(16'h1234));

        // R8, R9: sequence errors and clearing
        bus_write(16'h0000, 16'h0020);
        bus_write(16'h0000, 16'h0055);
        check("R8 no job on bad confirm", {15'd0, wsm_busy}, 16'h0000);
        read_check("R8 err p0", 16'h0000, exp_sr(1, 0, 1, 0));
        read_check("R8 p1 untouched", P1, exp_sr(1, 0, 0, 0));
        bus_write(P1, 16'h00A7);
        read_check("R8 undefined code p1", P1, exp_sr(1, 0, 1, 0));
        bus_write(16'h0000, 16'h00FF);
        read_check("R9 array with errors", 16'h0077, arr_fn(16'h0077));
        bus_write(16'h0000, 16'h0070);
        read_check("R9 error persists", 16'h0000, exp_sr(1, 0, 1, 0));
        bus_write(16'h0000, 16'h0050);
        read_check("R9 cleared p0", 16'h0000, exp_sr(1, 0, 0, 0));
        read_check("R9 p1 kept", P1, exp_sr(1, 0, 1, 0));
        bus_write(P1, 16'h0050);
        read_check("R9 cleared p1", P1, exp_sr(1, 0, 0, 0));
        bus_write(P1, 16'h0060);
        bus_write(P1, 16'h0001);
        read_check("R8 bad protection confirm", P1, exp_sr(1, 0, 1, 0));
        bus_write(P1, 16'h0050);

        // R12: protection job
        busy_samples = 0;
        bus_write(16'h0000, 16'h0060);
        bus_write(16'h0000, 16'h00D0);
        check("R12 busy", {15'd0, wsm_busy}, 16'h0001);
        wait_idle();
        check("R12 length", 16'(busy_samples), 16'(PC));

        // R11: erase suspend and resume
        busy_samples = 0;
        bus_write(P1, 16'h0020);
        bus_write(P1, 16'h00D0);
        repeat (6) @(negedge clk);
        bus_write(P1, 16'h00B0);
        check("R11 busy drops", {15'd0, wsm_busy}, 16'h0000);
        read_check("R11 erase paused status", P1, exp_sr(1, 1, 0, 0));
        read_check("R11 other partition", 16'h0000, exp_sr(1, 0, 0, 0));
        repeat (10) @(negedge clk);
        check("R11 stays paused", {15'd0, wsm_busy}, 16'h0000);
        bus_write(16'h0000, 16'h00FF);
        read_check("R11 array while paused", 16'h2A2A, arr_fn(16'h2A2A));
        bus_write(P1, 16'h00D0);
        check("R11 resumed", {15'd0, wsm_busy}, 16'h0001);
        wait_idle();
        check("R11 erase total", 16'(busy_samples), 16'(EC + 1));
        read_check("R11 done status", P1, exp_sr(1, 0, 0, 0));
        // program suspend
        busy_samples = 0;
        bus_write(16'h0000, 16'h0040);
        bus_write(16'h0005, 16'h1111);
        bus_write(16'h0000, 16'h00B0);
        read_check("R11 program paused status", 16'h0000, exp_sr(1, 0, 0, 1));
        bus_write(16'h0000, 16'h00D0);
        wait_idle();
        check("R11 program total", 16'(busy_samples), 16'(PC + 1));

        // R2: bus reset aborts job and clears state
        bus_write(P1, 16'h00A7);
        bus_write(16'h0000, 16'h0020);
        bus_write(16'h0000, 16'h00D0);
        @(negedge clk); bus_rst_n = 1'b0;
        @(negedge clk); @(negedge clk); bus_rst_n = 1'b1;
        check("R2 bus reset stops job", {15'd0, wsm_busy}, 16'h0000);
        read_check("R2 array after bus reset", 16'h0101, arr_fn(16'h0101));
        bus_write(16'h0000, 16'h0070);
        read_check("R2 errors cleared", P1, exp_sr(1, 0, 0, 0));

        // random mode / offset mix (R3, R4, R5)
        for (int i = 0; i < 150; i++) begin
            int m;
            logic [15:0] ra;
            m = $urandom_range(0, 3);
            bus_write(16'($urandom), (m == 0) ? 16'h00FF : (m == 1) ? 16'h0070 :
                                     (m == 2) ? 16'h0090 : 16'h0098);
            for (int j = 0; j < 2; j++) begin
                ra = 16'($urandom);
                if ($urandom_range(0, 1) == 1) ra = {ra[15], 13'd0, 2'($urandom_range(0, 3))};
                case (m)
                    0: read_check("R3 random array", ra, arr_fn(ra));
                    1: read_check("R4 random status", ra, exp_sr(1, 0, 0, 0));
                    2: read_check("R5 random ident", ra, exp_ident(ra[14:0]));
                    default: read_check("R5 random query", ra, exp_query(ra[14:0]));
                endcase
            end
        end

        @(negedge clk);
        check("R13 oe low after read", {15'd0, dq_oe}, 16'h0000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule